// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Scheduler

This block produces all the refresh traffic an asynchronous DRAM needs. It also runs the power-up initialisation before any host access is allowed. After reset it waits a fixed number of clock cycles. It then asks for a short burst of refresh cycles and raises a ready flag once the last one has finished. From then on an interval timer adds one owed refresh per refresh period. A saturating debt counter holds the number of refreshes still owed.

The block talks to the access sequencer through a request/grant handshake. The request stays high while any refresh is owed. The sequencer may postpone refreshes to serve the host until the debt reaches an urgency threshold. At that point the block withdraws host permission. When granted, the block drives the strobes itself with a CAS-before-RAS sequence. All column strobes move together, write-enable stays high and the address bus is left to the sequencer. Every timing value is a count of clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n`, every `cas_n` lane and `we_n` are 1, and `ready`, `ref_req`, `ref_urgent` and `host_ok` are 0.
- R2: After reset is released, `ref_req` stays 0 for the first INIT_WAIT_CYC clock edges and is 1 after edge INIT_WAIT_CYC.
- R3: `ready` stays 0 until INIT_REFS refresh sequences have completed. It becomes 1 in the cycle that follows the end of the last one.
- R4: A grant that is seen while `ref_req` is 1 and no sequence is running starts one. The sequence holds all strobes high for T_LEAD cycles. Column strobes then go low with `ras_n` high for T_CSR cycles. Both are then low for T_RAS cycles, and all are high for T_RP cycles before the block goes idle.
- R5: `we_n` is always 1, and all `cas_n` lanes carry the same value.
- R6: A grant has no effect while `ref_req` is 0: the strobes stay high.
- R7: After `ready` rises, one refresh becomes owed every REF_INTERVAL_CYC cycles. The first makes `ref_req` go from 0 to 1 exactly REF_INTERVAL_CYC cycles after `ready` rose.
- R8: `ref_req` stays 1 while the debt is non-zero, and each completed sequence lowers the debt by exactly one.
- R9: `ref_urgent` is 1 exactly when the debt is DEBT_URGENT or more, and `host_ok` is then 0.
- R10: The debt saturates at DEBT_MAX. Once the timer has added more refreshes than that, exactly DEBT_MAX sequences clear it.
- R11: `host_ok` is 1 only when `ready` is 1, `ref_urgent` is 0 and no sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Grant from the access sequencer, sampled while idle |
| ref_req | output | 1 | A refresh is wanted (initial burst or owed debt) |
| ref_urgent | output | 1 | Debt has reached the urgency threshold |
| ref_active | output | 1 | A refresh sequence owns the strobes |
| host_ok | output | 1 | Host accesses may be granted |
| ready | output | 1 | Initialisation is complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NUM_CAS | Column strobes, active low, driven together |
| we_n | output | 1 | Write enable, held high |

## Verification
The hardest state to reach is a saturated debt. It needs many refresh periods with no grant, and the drain must then finish between two timer ticks so that the count of sequences is exact. The bench counts cycles from the rise of `ready` and keeps its own model of the debt. It waits past a tick boundary before each measurement or drain. It then grants repeatedly and counts the sequences until `ref_req` drops. The urgency threshold is reached the same way, one interval at a time.

// File: rtl/dref_pkg.sv
package dref_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_CSR,
      PH_RAS,
      PH_PRE
   } phase_e;
endpackage

// File: rtl/dref_tick_gen.sv
module dref_tick_gen #(
   parameter int PERIOD = 1950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int TW = $clog2(PERIOD);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("dref_tick_gen: PERIOD must be at least 2");
      end
   endgenerate

   logic [TW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == TW'(PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en || wrap) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = en && wrap;
endmodule

// File: rtl/dref_debt_ctr.sv
module dref_debt_ctr #(
   parameter int DEBT_MAX    = 7,
   parameter int DEBT_URGENT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic pending,
   output logic urgent
);
   localparam int DW = $clog2(DEBT_MAX + 1);

   generate
      if (DEBT_MAX < 1) begin : g_bad_max
         $error("dref_debt_ctr: DEBT_MAX must be at least 1");
      end
      if (DEBT_URGENT < 1 || DEBT_URGENT > DEBT_MAX) begin : g_bad_urgent
         $error("dref_debt_ctr: DEBT_URGENT must lie in 1..DEBT_MAX");
      end
   endgenerate

   logic [DW-1:0] debt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt <= '0;
      end else begin
         case ({inc, dec})
            2'b10: if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
            2'b01: if (debt != '0) debt <= debt - 1'b1;
            default: debt <= debt;
         endcase
      end
   end

   assign pending = (debt != '0);
   assign urgent  = (debt >= DW'(DEBT_URGENT));
endmodule

// File: rtl/dref_init_ctl.sv
module dref_init_ctl #(
   parameter int WAIT_CYC  = 25000,
   parameter int INIT_REFS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seq_done,
   output logic init_pending,
   output logic ready
);
   localparam int WW = $clog2(WAIT_CYC + 1);
   localparam int RW = $clog2(INIT_REFS + 1);

   generate
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("dref_init_ctl: WAIT_CYC must be at least 1");
      end
      if (INIT_REFS < 1) begin : g_bad_refs
         $error("dref_init_ctl: INIT_REFS must be at least 1");
      end
   endgenerate

   logic [WW-1:0] wait_cnt;
   logic          wait_done;
   logic [RW-1:0] refs_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cnt  <= '0;
         wait_done <= 1'b0;
      end else if (!wait_done) begin
         if (wait_cnt == WW'(WAIT_CYC - 1)) begin
            wait_done <= 1'b1;
         end else begin
            wait_cnt <= wait_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         refs_left <= RW'(INIT_REFS);
         ready     <= 1'b0;
      end else if (seq_done && refs_left != '0) begin
         refs_left <= refs_left - 1'b1;
         if (refs_left == RW'(1)) begin
            ready <= 1'b1;
         end
      end
   end

   assign init_pending = wait_done && (refs_left != '0);
endmodule

// File: rtl/dref_strobe_seq.sv
module dref_strobe_seq
   import dref_pkg::*;
#(
   parameter int T_LEAD  = 1,
   parameter int T_CSR   = 2,
   parameter int T_RAS   = 8,
   parameter int T_RP    = 5,
   parameter int NUM_CAS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               active,
   output logic               done,
   output logic               ras_n,
   output logic [NUM_CAS-1:0] cas_n
);
   localparam int PW = $clog2(T_LEAD + T_CSR + T_RAS + T_RP + 1);

   generate
      if (T_LEAD < 1 || T_CSR < 1 || T_RAS < 1 || T_RP < 1) begin : g_bad_phase
         $error("dref_strobe_seq: every phase length must be at least 1");
      end
      if (NUM_CAS < 1) begin : g_bad_lanes
         $error("dref_strobe_seq: NUM_CAS must be at least 1");
      end
   endgenerate

   phase_e        ph, ph_nxt;
   logic [PW-1:0] cnt, cnt_nxt;
   logic          last;
   logic          ras_q, cas_q;

   assign last = (cnt == '0);

   always_comb begin
      ph_nxt  = ph;
      cnt_nxt = last ? cnt : cnt - 1'b1;
      case (ph)
         PH_IDLE: if (start) begin
            ph_nxt  = PH_LEAD;
            cnt_nxt = PW'(T_LEAD - 1);
         end
         PH_LEAD: if (last) begin
            ph_nxt  = PH_CSR;
            cnt_nxt = PW'(T_CSR - 1);
         end
         PH_CSR: if (last) begin
            ph_nxt  = PH_RAS;
            cnt_nxt = PW'(T_RAS - 1);
         end
         PH_RAS: if (last) begin
            ph_nxt  = PH_PRE;
            cnt_nxt = PW'(T_RP - 1);
         end
         PH_PRE: if (last) begin
            ph_nxt  = PH_IDLE;
         end
         default: begin
            ph_nxt  = PH_IDLE;
            cnt_nxt = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         ras_q <= 1'b1;
         cas_q <= 1'b1;
      end else begin
         ph    <= ph_nxt;
         cnt   <= cnt_nxt;
         ras_q <= (ph_nxt != PH_RAS);
         cas_q <= !(ph_nxt == PH_CSR || ph_nxt == PH_RAS);
      end
   end

   assign active = (ph != PH_IDLE);
   assign done   = (ph == PH_PRE) && last;
   assign ras_n  = ras_q;

   for (genvar g = 0; g < NUM_CAS; g++) begin : g_cas_lane
      assign cas_n[g] = cas_q;
   end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int INIT_WAIT_CYC    = 25000,
   parameter int INIT_REFS        = 8,
   parameter int REF_INTERVAL_CYC = 1950,
   parameter int DEBT_URGENT      = 4,
   parameter int DEBT_MAX         = 7,
   parameter int T_LEAD           = 1,
   parameter int T_CSR            = 2,
   parameter int T_RAS            = 8,
   parameter int T_RP             = 5,
   parameter int NUM_CAS          = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_gnt,
   output logic               ref_req,
   output logic               ref_urgent,
   output logic               ref_active,
   output logic               host_ok,
   output logic               ready,
   output logic               ras_n,
   output logic [NUM_CAS-1:0] cas_n,
   output logic               we_n
);
   logic init_pending;
   logic debt_pending;
   logic debt_urgent;
   logic tick;
   logic seq_done;
   logic seq_start;

   dref_init_ctl #(
      .WAIT_CYC (INIT_WAIT_CYC),
      .INIT_REFS(INIT_REFS)
   ) i_init (
      .clk         (clk),
      .rst_n       (rst_n),
      .seq_done    (seq_done),
      .init_pending(init_pending),
      .ready       (ready)
   );

   dref_tick_gen #(
      .PERIOD(REF_INTERVAL_CYC)
   ) i_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ready),
      .tick (tick)
   );

   dref_debt_ctr #(
      .DEBT_MAX   (DEBT_MAX),
      .DEBT_URGENT(DEBT_URGENT)
   ) i_debt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (tick),
      .dec    (seq_done && ready),
      .pending(debt_pending),
      .urgent (debt_urgent)
   );

   dref_strobe_seq #(
      .T_LEAD (T_LEAD),
      .T_CSR  (T_CSR),
      .T_RAS  (T_RAS),
      .T_RP   (T_RP),
      .NUM_CAS(NUM_CAS)
   ) i_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (seq_start),
      .active(ref_active),
      .done  (seq_done),
      .ras_n (ras_n),
      .cas_n (cas_n)
   );

   assign ref_req    = init_pending || (ready && debt_pending);
   assign ref_urgent = debt_urgent;
   assign seq_start  = ref_gnt && ref_req && !ref_active;
   assign host_ok    = ready && !debt_urgent && !ref_active;
   assign we_n       = 1'b1;
endmodule

// File: rtl/dref_sched_chk.sv
module dref_sched_chk #(
   parameter int NUM_CAS = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ref_req,
   input logic               ref_urgent,
   input logic               ref_active,
   input logic               host_ok,
   input logic               ready,
   input logic               ras_n,
   input logic [NUM_CAS-1:0] cas_n
);
   // R3
   ready_after_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(ref_active));

   // R4
   cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (cas_n == '0) && ($past(cas_n[0]) == 1'b0));

   // R4
   cas_fall_precharged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n[0]) |-> ras_n && $past(ras_n));

   // R6
   no_start_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_req && !ref_active) |=> !ref_active);

   // R11
   busy_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_active |-> !host_ok);

   // R9
   urgent_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> !host_ok);

   // R8
   urgent_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> ref_req);
endmodule

bind dram_refresh_sched dref_sched_chk #(.NUM_CAS(NUM_CAS)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_req   (ref_req),
   .ref_urgent(ref_urgent),
   .ref_active(ref_active),
   .host_ok   (host_ok),
   .ready     (ready),
   .ras_n     (ras_n),
   .cas_n     (cas_n)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
   localparam int WAITC = 40;
   localparam int NREF  = 8;
   localparam int IVL   = 300;
   localparam int URG   = 4;
   localparam int DMAX  = 7;
   localparam int TL    = 1;
   localparam int TC    = 2;
   localparam int TR    = 8;
   localparam int TP    = 5;
   localparam int TOT   = TL + TC + TR + TP;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_gnt = 1'b0;
   logic       ref_req, ref_urgent, ref_active, host_ok, ready, ras_n, we_n;
   logic [1:0] cas_n;

   int checks = 0;
   int fails = 0;
   int ncount = 0;
   int ready_at = 0;

   always #4 clk = ~clk;

   dram_refresh_sched #(
      .INIT_WAIT_CYC(WAITC), .INIT_REFS(NREF), .REF_INTERVAL_CYC(IVL),
      .DEBT_URGENT(URG), .DEBT_MAX(DMAX),
      .T_LEAD(TL), .T_CSR(TC), .T_RAS(TR), .T_RP(TP), .NUM_CAS(2)
   ) i_dram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
      .ref_urgent(ref_urgent), .ref_active(ref_active), .host_ok(host_ok),
      .ready(ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      ncount++;
   endtask

   task automatic wait_rel(input int target);
      while (ncount - ready_at < target) step();
   endtask

   // R4 R5 R11: one granted sequence, sampled every cycle
   task automatic do_refresh(input string tag);
      int bad_ras = 0, bad_cas = 0, bad_we = 0, bad_lane = 0, bad_host = 0;
      chk({tag, " R8 req before grant"}, int'(ref_req), 1);
      ref_gnt = 1'b1;
      step();
      ref_gnt = 1'b0;
      for (int j = 0; j < TOT; j++) begin
         int er, ec;
         if (j > 0) step();
         er = (j >= TL + TC && j < TL + TC + TR) ? 0 : 1;
         ec = (j >= TL && j < TL + TC + TR) ? 0 : 1;
         if (int'(ras_n) != er) bad_ras++;
         if (int'(cas_n[0]) != ec) bad_cas++;
         if (cas_n[0] != cas_n[1]) bad_lane++;
         if (we_n != 1'b1) bad_we++;
         if (host_ok != 1'b0) bad_host++;
      end
      chk({tag, " R4 ras_n pattern mismatches"}, bad_ras, 0);
      chk({tag, " R4 cas_n pattern mismatches"}, bad_cas, 0);
      chk({tag, " R5 lane or we_n mismatches"}, bad_lane + bad_we, 0);
      chk({tag, " R11 host_ok while busy"}, bad_host, 0);
      step();
      chk({tag, " R4 idle after precharge"}, int'(ref_active), 0);
   endtask

   task automatic t_reset();
      step();
      step();
      chk("R1 ras_n", int'(ras_n), 1);
      chk("R1 cas_n", int'(cas_n), 3);
      chk("R1 we_n", int'(we_n), 1);
      chk("R1 ready/req/urgent/host_ok", int'({ready, ref_req, ref_urgent, host_ok}), 0);
   endtask

   task automatic t_init_wait();
      int early = 0;
      rst_n = 1'b1;
      ncount = 0;
      for (int k = 1; k < WAITC; k++) begin
         step();
         if (ref_req) early++;
      end
      chk("R2 req during wait", early, 0);
      step();
      chk("R2 req after wait", int'(ref_req), 1);
      chk("R3 not ready during wait", int'(ready), 0);
   endtask

   task automatic t_init_burst();
      for (int n = 1; n <= NREF; n++) begin
         do_refresh("init");
         if (n == NREF - 1) chk("R3 ready before last init refresh", int'(ready), 0);
      end
      chk("R3 ready after burst", int'(ready), 1);
      chk("R11 host_ok after burst", int'(host_ok), 1);
      ready_at = ncount;
   endtask

   task automatic t_grant_ignored();
      int moved = 0;
      chk("R6 no req at start", int'(ref_req), 0);
      ref_gnt = 1'b1;
      for (int k = 0; k < 10; k++) begin
         step();
         if (!ras_n || cas_n != 2'b11 || ref_active) moved++;
      end
      ref_gnt = 1'b0;
      chk("R6 strobes moved on stray grant", moved, 0);
   endtask

   task automatic t_interval();
      wait_rel(IVL - 1);
      chk("R7 req before first interval", int'(ref_req), 0);
      step();
      chk("R7 req at first interval", int'(ref_req), 1);
      chk("R9 not urgent at debt 1", int'(ref_urgent), 0);
      chk("R11 host_ok with debt 1", int'(host_ok), 1);
   endtask

   task automatic t_debt_drain();
      wait_rel(2 * IVL + 2);
      do_refresh("debt2");
      chk("R8 req after one of two", int'(ref_req), 1);
      do_refresh("debt1");
      chk("R8 req cleared", int'(ref_req), 0);
   endtask

   task automatic t_urgent();
      wait_rel(5 * IVL + 2);
      chk("R9 not urgent at debt 3", int'(ref_urgent), 0);
      chk("R11 host_ok at debt 3", int'(host_ok), 1);
      wait_rel(6 * IVL + 2);
      chk("R9 urgent at debt 4", int'(ref_urgent), 1);
      chk("R9 host_ok blocked", int'(host_ok), 0);
   endtask

   task automatic t_saturate();
      int n = 0;
      wait_rel(12 * IVL + 2);
      while (ref_req && n < 20) begin
         do_refresh("drain");
         n++;
      end
      chk("R10 sequences to clear saturated debt", n, DMAX);
      chk("R9 urgent cleared", int'(ref_urgent), 0);
      chk("R11 host_ok restored", int'(host_ok), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_init_wait();
      t_init_burst();
      t_grant_ignored();
      t_interval();
      t_debt_drain();
      t_urgent();
      t_saturate();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule